// File: doc/BRIEF.md
# Binary Trie Longest Prefix Walker

This block resolves a destination address to a next hop by longest-prefix match. The routing table is kept as a binary trie in an on-chip node store. Every node carries a left child index, a right child index, a flag that says whether the node ends a stored prefix, and the next hop for that prefix. A lookup starts at the root and tests one address bit per level, starting at the most significant bit. On the way down it keeps the deepest prefix-bearing node it has passed. When the walk cannot go further, it returns that prefix.

Software or a control agent loads the trie one node per cycle through a write port. Lookups use a valid/ready request and a single-cycle response pulse. Only one lookup is in flight at a time. The response gives a hit flag, the next hop, and the length of the matched prefix.

Top module: `lpm_trie_walker`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o is 0.
- R2: At a node of depth d, address bit ADDR_W-1-d selects the next node. A value of 0 follows the left child index and a value of 1 follows the right child index, so the walk goes from the MSB downward.
- R3: The response gives the next hop of the deepest prefix-bearing node on the walked path. That node may be an interior node with children. rsp_len_o gives its depth, which is the prefix length.
- R4: If the address leaves a deeper branch before reaching a further prefix, the shorter prefix passed earlier is still returned.
- R5: A child index of 0 means null, because index 0 is the root. The walk stops at a node whose selected child is 0.
- R6: The walk stops after the node at depth ADDR_W has been examined, so a full-length (/32) prefix can match.
- R7: A prefix flag on the root acts as a default route. It gives a hit with rsp_len_o = 0 when nothing longer matches.
- R8: If no prefix-bearing node is passed, rsp_hit_o is 0 and rsp_nh_o and rsp_len_o are 0.
- R9: req_ready_o is 0 from the cycle after a request is accepted until the response cycle ends. Requests presented during that time are not taken and do not change the response.
- R10: rsp_valid_o rises exactly V clock edges after the accepting edge, where V is the number of nodes the walk visited. This is at most ADDR_W+1.
- R11: rsp_valid_o is high for one cycle per lookup, and rsp_len_o never exceeds ADDR_W.
- R12: A node write done while the block is idle takes effect for every later lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_ready_o | output | 1 | Block idle, request taken on this edge |
| req_addr_i | input | ADDR_W | Destination address to look up |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_hit_o | output | 1 | A prefix matched |
| rsp_nh_o | output | NH_W | Next hop of the longest match |
| rsp_len_o | output | LEN_W | Length of the matched prefix |
| node_we_i | input | 1 | Write one trie node |
| node_idx_i | input | IDX_W | Index of the node written |
| node_left_i | input | IDX_W | Left child index, 0 for none |
| node_right_i | input | IDX_W | Right child index, 0 for none |
| node_pfx_i | input | 1 | Node ends a stored prefix |
| node_nh_i | input | NH_W | Next hop stored at the node |

## Verification
The bench uses the default build: 32-bit addresses, 64 nodes and 8-bit next hops. With 64 nodes it can hold a complete 33-node chain for a /32 prefix next to a set of short prefixes that share branches. That reaches the full-depth stop and the worst-case latency of 33 visited nodes. It also reaches fallback from failed deep branches at many depths. Once the node pool is nearly full, the remaining random prefixes can no longer be inserted, so random lookups then run against a densely shared trie.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } walk_st_e;
endpackage

// File: rtl/lpm_node_mem.sv
module lpm_node_mem #(
  parameter int NUM_NODES = 64,
  parameter int WORD_W    = 21,
  parameter int IDX_W     = 6
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [WORD_W-1:0] mem_q [NUM_NODES];

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(wr_idx_i) < NUM_NODES)) mem_q[wr_idx_i] <= wr_word_i;
  end

  // synchronous read, old data on same-index collision
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_word_o <= mem_q[rd_idx_i];
  end
endmodule

// File: rtl/lpm_walker.sv
module lpm_walker
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int NH_W   = 8,
  parameter int LEN_W  = 6,
  parameter int WORD_W = 1 + NH_W + 2 * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [NH_W-1:0]   rsp_nh_o,
  output logic [LEN_W-1:0]  rsp_len_o,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [WORD_W-1:0] rd_word_i
);
  walk_st_e           st_q, st_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [LEN_W-1:0]   depth_q, depth_d;
  logic               best_hit_q, best_hit_d;
  logic [NH_W-1:0]    best_nh_q, best_nh_d;
  logic [LEN_W-1:0]   best_len_q, best_len_d;
  logic               rsp_hit_d;
  logic [NH_W-1:0]    rsp_nh_d;
  logic [LEN_W-1:0]   rsp_len_d;

  // node word fields
  logic               n_pfx;
  logic [NH_W-1:0]    n_nh;
  logic [IDX_W-1:0]   n_left, n_right, n_next;
  logic               cur_hit;
  logic [NH_W-1:0]    cur_nh;
  logic [LEN_W-1:0]   cur_len;
  logic               stop;

  assign {n_pfx, n_nh, n_left, n_right} = rd_word_i;
  assign n_next  = addr_q[ADDR_W-1] ? n_right : n_left;
  assign cur_hit = best_hit_q | n_pfx;
  assign cur_nh  = n_pfx ? n_nh : best_nh_q;
  assign cur_len = n_pfx ? depth_q : best_len_q;
  assign stop    = (depth_q == LEN_W'(ADDR_W)) || (n_next == '0);

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RESP);

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    depth_d    = depth_q;
    best_hit_d = best_hit_q;
    best_nh_d  = best_nh_q;
    best_len_d = best_len_q;
    rsp_hit_d  = rsp_hit_o;
    rsp_nh_d   = rsp_nh_o;
    rsp_len_d  = rsp_len_o;
    rd_en_o    = 1'b0;
    rd_idx_o   = '0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        rd_en_o    = 1'b1;
        addr_d     = req_addr_i;
        depth_d    = '0;
        best_hit_d = 1'b0;
        best_nh_d  = '0;
        best_len_d = '0;
        st_d       = ST_WALK;
      end
      ST_WALK: begin
        if (stop) begin
          rsp_hit_d = cur_hit;
          rsp_nh_d  = cur_hit ? cur_nh : '0;
          rsp_len_d = cur_hit ? cur_len : '0;
          st_d      = ST_RESP;
        end else begin
          rd_en_o    = 1'b1;
          rd_idx_o   = n_next;
          addr_d     = addr_q << 1;
          depth_d    = depth_q + 1'b1;
          best_hit_d = cur_hit;
          best_nh_d  = cur_nh;
          best_len_d = cur_len;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      addr_q     <= '0;
      depth_q    <= '0;
      best_hit_q <= 1'b0;
      best_nh_q  <= '0;
      best_len_q <= '0;
      rsp_hit_o  <= 1'b0;
      rsp_nh_o   <= '0;
      rsp_len_o  <= '0;
    end else begin
      st_q       <= st_d;
      addr_q     <= addr_d;
      depth_q    <= depth_d;
      best_hit_q <= best_hit_d;
      best_nh_q  <= best_nh_d;
      best_len_q <= best_len_d;
      rsp_hit_o  <= rsp_hit_d;
      rsp_nh_o   <= rsp_nh_d;
      rsp_len_o  <= rsp_len_d;
    end
  end
endmodule

// File: rtl/lpm_trie_walker.sv
module lpm_trie_walker #(
  parameter int ADDR_W    = 32,
  parameter int NUM_NODES = 64,
  parameter int NH_W      = 8,
  localparam int IDX_W    = $clog2(NUM_NODES),
  localparam int LEN_W    = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [NH_W-1:0]   rsp_nh_o,
  output logic [LEN_W-1:0]  rsp_len_o,
  input  logic              node_we_i,
  input  logic [IDX_W-1:0]  node_idx_i,
  input  logic [IDX_W-1:0]  node_left_i,
  input  logic [IDX_W-1:0]  node_right_i,
  input  logic              node_pfx_i,
  input  logic [NH_W-1:0]   node_nh_i
);
  localparam int WORD_W = 1 + NH_W + 2 * IDX_W;

  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;

  lpm_node_mem #(
    .NUM_NODES(NUM_NODES), .WORD_W(WORD_W), .IDX_W(IDX_W)
  ) u_mem (
    .clk_i    (clk_i),
    .we_i     (node_we_i),
    .wr_idx_i (node_idx_i),
    .wr_word_i({node_pfx_i, node_nh_i, node_left_i, node_right_i}),
    .rd_en_i  (rd_en),
    .rd_idx_i (rd_idx),
    .rd_word_o(rd_word)
  );

  lpm_walker #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NH_W(NH_W), .LEN_W(LEN_W), .WORD_W(WORD_W)
  ) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_addr_i (req_addr_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_hit_o  (rsp_hit_o),
    .rsp_nh_o   (rsp_nh_o),
    .rsp_len_o  (rsp_len_o),
    .rd_en_o    (rd_en),
    .rd_idx_o   (rd_idx),
    .rd_word_i  (rd_word)
  );
endmodule

// File: rtl/lpm_trie_walker_chk.sv
module lpm_trie_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int NH_W   = 8,
  parameter int LEN_W  = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_hit_o,
  input logic [NH_W-1:0]  rsp_nh_o,
  input logic [LEN_W-1:0] rsp_len_o
);
  logic [7:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_cnt_q <= '0;
    else if (req_ready_o) busy_cnt_q <= '0;
    else                  busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  AST_RSP_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);                                        // R9
  AST_READY_AFTER_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> req_ready_o);                                         // R9
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);                                        // R11
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (int'(rsp_len_o) <= ADDR_W));                         // R11
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_nh_o == '0 && rsp_len_o == '0)); // R8
  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> (int'(busy_cnt_q) <= ADDR_W + 1));                   // R10
endmodule

bind lpm_trie_walker lpm_trie_walker_chk #(
  .ADDR_W(ADDR_W), .NH_W(NH_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .rsp_hit_o  (rsp_hit_o),
  .rsp_nh_o   (rsp_nh_o),
  .rsp_len_o  (rsp_len_o)
);

// File: tb/lpm_trie_walker_bench.sv
module lpm_trie_walker_bench;
  localparam int ADDR_W    = 32;
  localparam int NUM_NODES = 64;
  localparam int NH_W      = 8;
  localparam int IDX_W     = $clog2(NUM_NODES);
  localparam int LEN_W     = $clog2(ADDR_W + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid, rsp_hit;
  logic [NH_W-1:0]   rsp_nh;
  logic [LEN_W-1:0]  rsp_len;
  logic              n_we = 1'b0;
  logic [IDX_W-1:0]  n_idx = '0, n_left = '0, n_right = '0;
  logic              n_pfx = 1'b0;
  logic [NH_W-1:0]   n_nh = '0;

  int errors = 0;
  int checks = 0;

  // bench model of the trie
  int m_left [NUM_NODES];
  int m_right[NUM_NODES];
  int m_pfx  [NUM_NODES];
  int m_nh   [NUM_NODES];
  int next_free = 1;

  always #2 clk = ~clk;

  lpm_trie_walker #(.ADDR_W(ADDR_W), .NUM_NODES(NUM_NODES), .NH_W(NH_W)) u_lpm_trie_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_nh_o(rsp_nh), .rsp_len_o(rsp_len),
    .node_we_i(n_we), .node_idx_i(n_idx), .node_left_i(n_left), .node_right_i(n_right),
    .node_pfx_i(n_pfx), .node_nh_i(n_nh)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_node(input int idx);
    @(negedge clk);
    n_we = 1'b1; n_idx = IDX_W'(idx);
    n_left = IDX_W'(m_left[idx]); n_right = IDX_W'(m_right[idx]);
    n_pfx = m_pfx[idx][0]; n_nh = NH_W'(m_nh[idx]);
    @(posedge clk);
    @(negedge clk);
    n_we = 1'b0;
  endtask

  task automatic insert(input logic [ADDR_W-1:0] pfx, input int len, input int nh, output bit ok);
    int cur = 0;
    ok = 1'b1;
    for (int d = 0; d < len; d++) begin
      int nxt = pfx[ADDR_W-1-d] ? m_right[cur] : m_left[cur];
      if (nxt == 0) begin
        if (next_free >= NUM_NODES) begin ok = 1'b0; return; end
        nxt = next_free++;
        m_left[nxt] = 0; m_right[nxt] = 0; m_pfx[nxt] = 0; m_nh[nxt] = 0;
        write_node(nxt);
        if (pfx[ADDR_W-1-d]) m_right[cur] = nxt; else m_left[cur] = nxt;
        write_node(cur);
      end
      cur = nxt;
    end
    m_pfx[cur] = 1; m_nh[cur] = nh;
    write_node(cur);
  endtask

  // reference lookup from the requirements: returns hit, nh, len, visited nodes
  function automatic void ref_lookup(input logic [ADDR_W-1:0] a,
      output bit hit, output int nh, output int len, output int visited);
    int cur = 0;
    hit = 0; nh = 0; len = 0; visited = 0;
    for (int d = 0; d <= ADDR_W; d++) begin
      int nxt;
      visited++;
      if (m_pfx[cur] != 0) begin hit = 1; nh = m_nh[cur]; len = d; end
      if (d == ADDR_W) break;
      nxt = a[ADDR_W-1-d] ? m_right[cur] : m_left[cur];
      if (nxt == 0) break;
      cur = nxt;
    end
  endfunction

  task automatic lookup(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] alt, input bit hold_busy,
      output bit hit, output int nh, output int len, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk);
    lat = 0;
    @(negedge clk);
    if (hold_busy) req_addr = alt; else req_valid = 1'b0;
    while (!rsp_valid && lat < 40) begin
      if (hold_busy) chk(!req_ready, "R9 ready low while busy", req_ready, 0);
      @(posedge clk); lat++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    hit = rsp_hit; nh = int'(rsp_nh); len = int'(rsp_len);
  endtask

  task automatic check_addr(input logic [ADDR_W-1:0] a, input string req);
    bit h, eh; int nh, len, lat, enh, elen, ev;
    ref_lookup(a, eh, enh, elen, ev);
    lookup(a, '0, 1'b0, h, nh, len, lat);
    chk(h == eh, {req, " hit"}, h, eh);
    chk(nh == enh, {req, " nh"}, nh, enh);
    chk(len == elen, {req, " len"}, len, elen);
    chk(lat == ev, "R10 latency", lat, ev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bit ok, h;
    int nh, len, lat, cnt;
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < NUM_NODES; i++) begin
      m_left[i] = 0; m_right[i] = 0; m_pfx[i] = 0; m_nh[i] = 0;
    end
    #1;
    chk(req_ready == 1'b1, "R1 ready at reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response at reset", rsp_valid, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < NUM_NODES; i++) write_node(i);

    // empty trie: root only, null children
    lookup(32'h1234_5678, '0, 1'b0, h, nh, len, lat);
    chk(h == 1'b0 && nh == 0 && len == 0, "R8 miss on empty trie", {h, 8'(nh)}, 0);
    chk(lat == 1, "R5 stop at null child", lat, 1);

    // default route on root
    m_pfx[0] = 1; m_nh[0] = 8'h11; write_node(0);
    lookup(32'hFFFF_0000, '0, 1'b0, h, nh, len, lat);
    chk(h && nh == 8'h11 && len == 0, "R7 default route", nh, 8'h11);
    m_pfx[0] = 0; m_nh[0] = 0; write_node(0);

    // small shared prefix set
    insert(32'h8000_0000, 2, 8'h21, ok);  // 10
    insert(32'hE000_0000, 3, 8'h22, ok);  // 111
    insert(32'hC800_0000, 5, 8'h23, ok);  // 11001
    insert(32'h8000_0000, 1, 8'h24, ok);  // 1
    insert(32'h0000_0000, 1, 8'h25, ok);  // 0
    insert(32'h8000_0000, 4, 8'h26, ok);  // 1000
    insert(32'h8000_0000, 6, 8'h27, ok);  // 100000
    insert(32'h8000_0000, 7, 8'h28, ok);  // 1000000

    check_addr(32'hC800_0000, "R2 right/left steering");
    check_addr(32'h8000_0000, "R3 deepest of nested prefixes");
    lookup(32'h8000_0000, '0, 1'b0, h, nh, len, lat);
    chk(nh == 8'h28 && len == 7, "R3 /7 beats interior /4 and /6", nh, 8'h28);
    lookup(32'hC000_0000, '0, 1'b0, h, nh, len, lat);
    chk(nh == 8'h24 && len == 1, "R4 fallback to /1 after failed branch", nh, 8'h24);
    lookup(32'h8400_0000, '0, 1'b0, h, nh, len, lat);
    chk(nh == 8'h26 && len == 4, "R4 fallback to /4", nh, 8'h26);
    lookup(32'h4000_0000, '0, 1'b0, h, nh, len, lat);
    chk(nh == 8'h25 && len == 1, "R2 bit0 selects left child", nh, 8'h25);

    // full-length prefix
    insert(32'hDEAD_BEEF, 32, 8'h5A, ok);
    chk(ok, "R6 chain inserted", ok, 1);
    lookup(32'hDEAD_BEEF, '0, 1'b0, h, nh, len, lat);
    chk(nh == 8'h5A && len == 32, "R6 /32 match", len, 32);
    chk(lat == ADDR_W + 1, "R10 worst-case latency", lat, ADDR_W + 1);
    check_addr(32'hDEAD_BEEE, "R4 last bit differs");

    // busy: second request must not be taken
    lookup(32'hC800_0000, 32'h0000_0000, 1'b1, h, nh, len, lat);
    chk(nh == 8'h23 && len == 5, "R9 busy request ignored", nh, 8'h23);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R9 idle again, no extra response", {req_ready, rsp_valid}, 2);

    // rewrite a node while idle
    m_nh[7] = 8'h99; write_node(7);
    check_addr(32'hC800_0000, "R12 rewritten node");

    // random prefixes until pool is full, then random lookups
    cnt = 0;
    do begin
      logic [ADDR_W-1:0] p = $urandom;
      insert(p, 1 + int'($urandom_range(11)), int'($urandom_range(255)), ok);
      cnt++;
    end while (ok && cnt < 40);
    for (int i = 0; i < 300; i++) begin
      logic [ADDR_W-1:0] a = $urandom;
      if (i % 3 == 0) a = {8'hDE, 8'hAD, 16'($urandom)};
      check_addr(a, "R3 random lookup");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule